// File: doc/BRIEF.md
# Line Driver Short-Circuit Retry Controller

This block sits between the transmit symbol source and a bipolar line driver. It watches a short-detect flag from the analog driver, which rises when either driver output is tied to a supply rail or to ground, or when the two outputs are tied together. While the driver is enabled it passes each requested bipolar symbol (+1, 0 or -1) through to the driver, one per transmit clock.

When a short is seen, the block disables the driver for a fixed guard interval counted in transmit clocks. Symbols requested during that interval are dropped. After the interval the driver is enabled again and the next symbol is tried. If the short is still present on that retry, another guard interval starts. The loop repeats until a symbol goes out with no short flagged. No external clear is needed. An alarm flag for use inside the chip shows that the transmitter is in trouble.

Top module: `short_retry_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the driver enabled (`drvEnable`=1) with `shortAlarm`=0 on the cycle after the reset edge.
- R2: While the driver is enabled, `symOut` equals `symIn` in the same cycle. The symbol codes are {pos,neg}: 2'b10 is +1, 2'b01 is -1, 2'b00 is 0.
- R3: The undefined code 2'b11 on `symIn` is sent as 0 (2'b00) and never drives both rails.
- R4: `shortDet` high at a rising clock edge while the driver is enabled makes `drvEnable` low from the cycle after that edge.
- R5: The guard interval lasts exactly `PROTECT_CYCLES` (default 35) clock cycles of `drvEnable`=0. The driver is then re-enabled.
- R6: While the driver is disabled, `symOut` is 2'b00 whatever `symIn` is, and the symbols requested in that time are not sent later.
- R7: `shortDet` during a guard interval is ignored: it neither extends nor restarts the interval.
- R8: A short sampled on the first enabled cycle after a guard interval starts another full guard interval. This repeats for as long as the short persists.
- R9: `shortAlarm` rises on the cycle after a short is acted on and stays high until an edge at which the driver is enabled and `shortDet` is low. It drops on the following cycle.
- R10: A reset during a guard interval ends it at once: the driver is enabled and the alarm is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| shortDet | input | 1 | Short indication from the line driver |
| symIn | input | 2 | Requested bipolar symbol {pos,neg} |
| drvEnable | output | 1 | Driver enable; low means protected |
| symOut | output | 2 | Symbol passed to the driver {pos,neg} |
| shortAlarm | output | 1 | Alarm for use inside the chip only |

## Verification
A single-cycle short pulse followed by a short held high through the whole guard interval but dropped at the retry shows that the interval has the exact length and is not extended. A short that is still present at the retry tells a true re-arm apart from a single timeout. A reset asserted in the middle of an interval shows that reset has priority over the counter. Random symbols, with sparse random shorts and resets, compare `symOut`, `drvEnable` and `shortAlarm` every cycle against a cycle model written from the requirements. This covers all four symbol codes, both inside and outside protection.

// File: rtl/short_retry_pkg.sv
package short_retry_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_GUARD = 1'b1} ctrlState_t;

  typedef struct packed {
    logic passSym;
    logic clearCnt;
    logic incCnt;
  } ctrlStrobes_t;

  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_BAD  = 2'b11;
endpackage

// File: rtl/short_retry_datapath.sv
module short_retry_datapath
  import short_retry_pkg::*;
#(
  parameter int PROTECT_CYCLES = 35,
  parameter int SYM_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strb,
  input  logic [SYM_W-1:0] symIn,
  output logic             cntLast,
  output logic [SYM_W-1:0] symOut
);
  localparam int CNT_W = (PROTECT_CYCLES > 1) ? $clog2(PROTECT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(PROTECT_CYCLES - 1);

  logic [CNT_W-1:0] guardCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      guardCnt <= '0;
    end else if (strb.clearCnt) begin
      guardCnt <= '0;
    end else if (strb.incCnt) begin
      guardCnt <= guardCnt + 1'b1;
    end
  end

  assign cntLast = (guardCnt == LAST_VAL);

  // Both rails high is never legal on a bipolar line; send a zero instead.
  logic symLegal;
  assign symLegal = (symIn != SYM_BAD);

  always_comb begin
    symOut = SYM_ZERO;
    if (strb.passSym && symLegal) begin
      symOut = symIn;
    end
  end
endmodule

// File: rtl/short_retry_control.sv
module short_retry_control
  import short_retry_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         shortDet,
  input  logic         cntLast,
  output ctrlStrobes_t strb,
  output logic         drvEnable,
  output logic         shortAlarm
);
  ctrlState_t state, stateNext;
  logic alarmNext;

  always_comb begin
    stateNext = state;
    alarmNext = shortAlarm;
    unique case (state)
      ST_RUN: begin
        if (shortDet) begin
          stateNext = ST_GUARD;
          alarmNext = 1'b1;
        end else begin
          alarmNext = 1'b0;
        end
      end
      ST_GUARD: begin
        if (cntLast) begin
          stateNext = ST_RUN;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      shortAlarm <= 1'b0;
    end else begin
      state      <= stateNext;
      shortAlarm <= alarmNext;
    end
  end

  always_comb begin
    strb.passSym  = (state == ST_RUN);
    strb.clearCnt = (state == ST_RUN);
    strb.incCnt   = (state == ST_GUARD);
  end

  assign drvEnable = (state == ST_RUN);
endmodule

// File: rtl/short_retry_ctrl.sv
module short_retry_ctrl
  import short_retry_pkg::*;
#(
  parameter int PROTECT_CYCLES = 35
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       shortDet,
  input  logic [1:0] symIn,
  output logic       drvEnable,
  output logic [1:0] symOut,
  output logic       shortAlarm
);
  ctrlStrobes_t strb;
  logic cntLast;

  short_retry_control u_control (
    .clk       (clk),
    .rst       (rst),
    .shortDet  (shortDet),
    .cntLast   (cntLast),
    .strb      (strb),
    .drvEnable (drvEnable),
    .shortAlarm(shortAlarm)
  );

  short_retry_datapath #(
    .PROTECT_CYCLES(PROTECT_CYCLES),
    .SYM_W         (2)
  ) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .symIn  (symIn),
    .cntLast(cntLast),
    .symOut (symOut)
  );
endmodule

// File: rtl/short_retry_checker.sv
module short_retry_checker #(
  parameter int PROTECT_CYCLES = 35
) (
  input logic       clk,
  input logic       rst,
  input logic       shortDet,
  input logic [1:0] symIn,
  input logic       drvEnable,
  input logic [1:0] symOut,
  input logic       shortAlarm
);
  localparam int RUN_W = $clog2(PROTECT_CYCLES + 2) + 1;
  logic [RUN_W-1:0] runLen;

  // Counts the disabled cycles seen so far in the current guard run.
  always_ff @(posedge clk) begin
    if (rst || drvEnable) runLen <= '0;
    else                  runLen <= runLen + 1'b1;
  end

  p_enter_r4: assert property (@(posedge clk) disable iff (rst)
    (drvEnable && shortDet) |=> !drvEnable);

  p_window_max_r5: assert property (@(posedge clk) disable iff (rst)
    !drvEnable |-> (runLen < RUN_W'(PROTECT_CYCLES)));

  p_window_len_r5: assert property (@(posedge clk) disable iff (rst)
    (drvEnable && runLen != '0) |-> (runLen == RUN_W'(PROTECT_CYCLES)));

  p_drop_r6: assert property (@(posedge clk) disable iff (rst)
    !drvEnable |-> (symOut == 2'b00));

  p_no_both_rails_r3: assert property (@(posedge clk) disable iff (rst)
    symOut != 2'b11);

  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (drvEnable && symIn != 2'b11) |-> (symOut == symIn));

  p_alarm_set_r9: assert property (@(posedge clk) disable iff (rst)
    (drvEnable && shortDet) |=> shortAlarm);

  p_alarm_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (drvEnable && !shortDet) |=> !shortAlarm);

  p_alarm_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !drvEnable |=> $stable(shortAlarm));
endmodule

bind short_retry_ctrl short_retry_checker #(.PROTECT_CYCLES(PROTECT_CYCLES)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .shortDet  (shortDet),
  .symIn     (symIn),
  .drvEnable (drvEnable),
  .symOut    (symOut),
  .shortAlarm(shortAlarm)
);

// File: tb/short_retry_ctrl_bench.sv
`timescale 1ns/1ps
module short_retry_ctrl_bench;
  localparam int N = 35;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shortDet = 1'b0;
  logic [1:0] symIn = 2'b00;
  logic drvEnable;
  logic [1:0] symOut;
  logic shortAlarm;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Cycle model built from the requirements.
  bit mProt = 1'b0;
  int mCnt = 0;
  bit mAlarm = 1'b0;
  bit obsEn;
  logic [1:0] obsSym;
  bit obsAlarm;

  always #10 clk = ~clk;

  short_retry_ctrl #(.PROTECT_CYCLES(N)) u_short_retry_ctrl (
    .clk(clk), .rst(rst), .shortDet(shortDet), .symIn(symIn),
    .drvEnable(drvEnable), .symOut(symOut), .shortAlarm(shortAlarm)
  );

  function automatic logic [1:0] expSym(bit prot, logic [1:0] s);
    if (prot || s == 2'b11) return 2'b00;
    return s;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic step(logic [1:0] s, bit sh, bit r, bit chk);
    @(negedge clk);
    symIn = s; shortDet = sh; rst = r;
    #1;
    obsEn = drvEnable; obsSym = symOut; obsAlarm = shortAlarm;
    if (chk) begin
      check(obsEn == !mProt, "R5 drvEnable", int'(obsEn), int'(!mProt));
      check(obsSym == expSym(mProt, s), "R2 symOut", int'(obsSym), int'(expSym(mProt, s)));
      check(obsAlarm == mAlarm, "R9 shortAlarm", int'(obsAlarm), int'(mAlarm));
    end
    @(posedge clk);
    if (r) begin
      mProt = 0; mCnt = 0; mAlarm = 0;
    end else if (!mProt) begin
      if (sh) begin mProt = 1; mCnt = 0; mAlarm = 1; end
      else mAlarm = 0;
    end else begin
      if (mCnt == N - 1) mProt = 0;
      else mCnt++;
    end
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lows;
    void'($urandom(32'd1234));
    step(2'b00, 0, 1, 0);
    step(2'b00, 0, 1, 0);
    // R1: state just after reset
    step(2'b10, 0, 0, 1);
    check(obsEn == 1, "R1 enable after reset", int'(obsEn), 1);
    check(obsAlarm == 0, "R1 alarm after reset", int'(obsAlarm), 0);
    // R2: each symbol code
    step(2'b01, 0, 0, 1);
    check(obsSym == 2'b01, "R2 minus passed", int'(obsSym), 1);
    // R3: illegal code
    step(2'b11, 0, 0, 1);
    check(obsSym == 2'b00, "R3 illegal code zeroed", int'(obsSym), 0);

    // R4, R5, R7: single detect, short held during guard, gone at retry
    step(2'b10, 1, 0, 1);
    lows = 0;
    for (int i = 0; i < N; i++) begin
      step(2'b10, 1, 0, 1);
      if (!obsEn) lows++;
      if (i == 0) check(obsEn == 0, "R4 disable next cycle", int'(obsEn), 0);
      if (i == 3) check(obsSym == 2'b00, "R6 symbol dropped", int'(obsSym), 0);
    end
    check(lows == N, "R5 guard length", lows, N);
    step(2'b01, 0, 0, 1);
    check(obsEn == 1, "R7 not extended by short in guard", int'(obsEn), 1);
    check(obsAlarm == 1, "R9 alarm held until clean symbol", int'(obsAlarm), 1);
    step(2'b10, 0, 0, 1);
    check(obsAlarm == 0, "R9 alarm cleared", int'(obsAlarm), 0);

    // R8: short persists at retry
    step(2'b10, 1, 0, 1);
    for (int i = 0; i < N; i++) step(2'b01, 0, 0, 1);
    step(2'b10, 1, 0, 1);
    check(obsEn == 1, "R8 retry enabled", int'(obsEn), 1);
    lows = 0;
    for (int i = 0; i < N; i++) begin
      step(2'b10, 0, 0, 1);
      if (!obsEn) lows++;
    end
    check(lows == N, "R8 second guard full length", lows, N);
    check(obsAlarm == 1, "R9 alarm across retries", int'(obsAlarm), 1);
    step(2'b00, 0, 0, 1);
    check(obsEn == 1, "R8 recovered", int'(obsEn), 1);

    // R10: reset inside guard
    step(2'b10, 1, 0, 1);
    for (int i = 0; i < 5; i++) step(2'b10, 0, 0, 1);
    step(2'b10, 0, 1, 0);
    step(2'b10, 0, 0, 1);
    check(obsEn == 1, "R10 reset ends guard", int'(obsEn), 1);
    check(obsAlarm == 0, "R10 reset clears alarm", int'(obsAlarm), 0);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] s;
      bit sh, r;
      s = 2'($urandom % 4);
      sh = ($urandom % 25) == 0;
      r = ($urandom % 700) == 0;
      step(s, sh, r, 1);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule